// File: doc/BRIEF.md
# Cache line snoop controller

This block keeps the tag, valid, dirty and data state of a small direct-mapped data cache and answers bus snoops from another master. Each snoop carries a 2-bit control code whose meaning depends on the direction of the transfer. On a hit the block can do one of three things: supply a dirty longword, absorb a partial write into the line, or invalidate the line. When it intervenes, it asserts memory inhibit and slave acknowledge one cycle after the request.

The same array also serves processor accesses. A copyback write that hits merges its bytes into the line and marks each written longword dirty, with no external write. A write-through write that hits updates the data and leaves the dirty bits alone. A line-install port loads a clean line from the fill logic, which sits outside this block.

The array has one port. A snoop wins it over an install, and an install wins it over the processor. A stalled processor request is retried by the requester.

Top module: `snoop_ctrl`

## Requirements
- R1: Snoop code 00 and code 11 leave the array unchanged and keep memory inhibit and slave acknowledge low, for reads and for writes.
- R2: A snoop read with code 01 that hits a line with any dirty bit set asserts inhibit and acknowledge and returns the addressed longword on snp_rdata. The line stays valid and dirty.
- R3: A snoop read with code 10 that hits a dirty line returns the longword as in R2 and then clears the line's valid bit and dirty bits.
- R4: A snoop read that misses, or that hits a clean line, does not intervene and does not change the line.
- R5: A snoop write with code 10 that hits a valid line invalidates it without intervening.
- R6: A snoop write of line size (size 11) with code 01 or 10 that hits a valid line invalidates it, and inhibit stays low.
- R7: A snoop byte, word or longword write (size 00, 01, 10) with code 01 that hits a dirty line asserts inhibit and acknowledge. It merges the enabled bytes into the addressed longword and sets that longword's dirty bit.
- R8: A partial snoop write with code 01 that hits a clean valid line invalidates the line and does not assert inhibit.
- R9: A processor copyback write that hits merges its enabled bytes into the addressed longword and sets that longword's dirty bit. The line then counts as dirty.
- R10: A processor write-through write that hits updates the data and sets no dirty bit.
- R11: If a snoop and a processor request arrive in the same cycle, cpu_stall is high, the snoop is performed, and cpu_done stays low. The processor request completes only on a later cycle with no snoop.
- R12: Snoops act the same whatever the value of cache_en. While cache_en is low, processor accesses report a miss and change nothing.
- R13: The byte enable is derived from the size and address bits [1:0]. A byte selects lane addr[1:0]. A word selects lanes 3:2 if addr[1] is set and lanes 1:0 otherwise. A longword selects all four lanes. Lane i is data bits 8i+7:8i.
- R14: Snoop and processor responses appear on the outputs in the cycle after the request is sampled. After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Enables processor hits |
| snp_valid | input | 1 | A snoopable transfer is on the bus |
| snp_write | input | 1 | 1 = write by the other master |
| snp_code | input | 2 | Snoop control code |
| snp_size | input | 2 | 00 byte, 01 word, 10 longword, 11 line |
| snp_addr | input | AW | Snoop byte address |
| snp_wdata | input | 32 | Snoop write data |
| snp_inhibit | output | 1 | Memory inhibit |
| snp_ack | output | 1 | Slave acknowledge from the cache |
| snp_rdata | output | 32 | Supplied dirty longword |
| ins_valid | input | 1 | Install a clean line |
| ins_addr | input | AW-4 | Line address of install |
| ins_data | input | 128 | Line data, longword i at bits 32i+31:32i |
| cpu_req | input | 1 | Processor access request |
| cpu_write | input | 1 | 1 = write |
| cpu_copyback | input | 1 | 1 = copyback page, 0 = write-through |
| cpu_addr | input | AW-2 | Processor longword address |
| cpu_be | input | 4 | Processor byte enables |
| cpu_wdata | input | 32 | Processor write data |
| cpu_stall | output | 1 | Array busy this cycle; retry |
| cpu_done | output | 1 | Processor access completed |
| cpu_hit | output | 1 | Completed access hit |
| cpu_rdata | output | 32 | Longword after the access |

## Verification
Every snoop code is driven against three line states: dirty, clean but valid, and absent. This separates the cases where the block intervenes, where it only invalidates, and where it is silent. Writes are applied at byte, word, longword and line size at different lane offsets, and the bytes that come back show whether the lane selection and the merge are right. Processor copyback and write-through writes are then probed with a snoop read, because only a dirty line causes an intervention. A snoop and a processor request that collide in one cycle show which of them owns the array.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_RD_KEEP,
        OP_RD_DROP,
        OP_WR_SINK,
        OP_WR_DROP
    } snp_op_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;
    localparam logic [1:0] SZ_LONG = 2'b10;
    localparam logic [1:0] SZ_LINE = 2'b11;
    localparam int         LW_PER_LINE = 4;
endpackage

// File: rtl/snoop_decode.sv
module snoop_decode
    import snoop_pkg::*;
(
    input  logic       wr,
    input  logic [1:0] code,
    input  logic [1:0] size,
    input  logic [1:0] lo,
    output snp_op_e    op,
    output logic [3:0] be
);
    always_comb begin
        op = OP_NONE;
        if (code == 2'b01 || code == 2'b10) begin
            if (!wr)                op = (code == 2'b01) ? OP_RD_KEEP : OP_RD_DROP;
            else if (size == SZ_LINE) op = OP_WR_DROP;
            else                      op = (code == 2'b01) ? OP_WR_SINK : OP_WR_DROP;
        end
    end

    always_comb begin
        case (size)
            SZ_BYTE: be = 4'b0001 << lo;
            SZ_WORD: be = lo[1] ? 4'b1100 : 4'b0011;
            default: be = 4'b1111;
        endcase
    end

    always_comb begin
        if (size == SZ_BYTE)
            assert_byte_lane_R13: assert ($countones(be) == 1 && be[lo]);
        if (size == SZ_WORD)
            assert_word_lane_R13: assert ($countones(be) == 2 && be[{lo[1], 1'b0}]);
    end
endmodule

// File: rtl/lane_merge.sv
module lane_merge #(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0] old_w,
    input  logic [LANES*8-1:0] new_w,
    input  logic [LANES-1:0]   be,
    output logic [LANES*8-1:0] out_w
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign out_w[i*8 +: 8] = be[i] ? new_w[i*8 +: 8] : old_w[i*8 +: 8];
    end
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
    import snoop_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LINES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cache_en,
    input  logic          snp_valid,
    input  logic          snp_write,
    input  logic [1:0]    snp_code,
    input  logic [1:0]    snp_size,
    input  logic [AW-1:0] snp_addr,
    input  logic [31:0]   snp_wdata,
    output logic          snp_inhibit,
    output logic          snp_ack,
    output logic [31:0]   snp_rdata,
    input  logic          ins_valid,
    input  logic [AW-5:0] ins_addr,
    input  logic [127:0]  ins_data,
    input  logic          cpu_req,
    input  logic          cpu_write,
    input  logic          cpu_copyback,
    input  logic [AW-3:0] cpu_addr,
    input  logic [3:0]    cpu_be,
    input  logic [31:0]   cpu_wdata,
    output logic          cpu_stall,
    output logic          cpu_done,
    output logic          cpu_hit,
    output logic [31:0]   cpu_rdata
);
    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW - 4;

    typedef struct packed {
        logic [TW-1:0]                       tag;
        logic                                valid;
        logic [LW_PER_LINE-1:0]              dirty;
        logic [LW_PER_LINE-1:0][31:0]        data;
    } line_t;

    typedef struct packed {
        line_t [LINES-1:0] arr;
        logic              inh;
        logic              ack;
        logic [31:0]       srd;
        logic              cdone;
        logic              chit;
        logic [31:0]       crd;
    } state_t;

    state_t st_d, st_q;

    // snoop address split
    logic [IW-1:0] s_idx;
    logic [TW-1:0] s_tag;
    logic [1:0]    s_lw;
    logic          s_hit, s_dirty;
    snp_op_e       s_op;
    logic [3:0]    s_be;
    logic [31:0]   s_old, s_merged;

    assign s_idx = snp_addr[IW+3:4];
    assign s_tag = snp_addr[AW-1:IW+4];
    assign s_lw  = snp_addr[3:2];
    assign s_hit   = st_q.arr[s_idx].valid && (st_q.arr[s_idx].tag == s_tag);
    assign s_dirty = s_hit && (|st_q.arr[s_idx].dirty);
    assign s_old   = st_q.arr[s_idx].data[s_lw];

    snoop_decode u_dec (
        .wr   (snp_write),
        .code (snp_code),
        .size (snp_size),
        .lo   (snp_addr[1:0]),
        .op   (s_op),
        .be   (s_be)
    );

    lane_merge #(.LANES(4)) u_smerge (
        .old_w (s_old),
        .new_w (snp_wdata),
        .be    (s_be),
        .out_w (s_merged)
    );

    // processor address split
    logic [IW-1:0] c_idx;
    logic [TW-1:0] c_tag;
    logic [1:0]    c_lw;
    logic          c_hit;
    logic [31:0]   c_old, c_merged;

    assign c_idx = cpu_addr[IW+1:2];
    assign c_tag = cpu_addr[AW-3:IW+2];
    assign c_lw  = cpu_addr[1:0];
    assign c_hit = cache_en && st_q.arr[c_idx].valid && (st_q.arr[c_idx].tag == c_tag);
    assign c_old = st_q.arr[c_idx].data[c_lw];

    lane_merge #(.LANES(4)) u_cmerge (
        .old_w (c_old),
        .new_w (cpu_wdata),
        .be    (cpu_be),
        .out_w (c_merged)
    );

    logic [IW-1:0] i_idx;
    assign i_idx = ins_addr[IW-1:0];

    always_comb begin
        st_d       = st_q;
        st_d.inh   = 1'b0;
        st_d.ack   = 1'b0;
        st_d.srd   = '0;
        st_d.cdone = 1'b0;
        st_d.chit  = 1'b0;
        st_d.crd   = '0;
        if (snp_valid) begin
            case (s_op)
                OP_RD_KEEP, OP_RD_DROP: begin
                    if (s_dirty) begin
                        st_d.inh = 1'b1;
                        st_d.ack = 1'b1;
                        st_d.srd = s_old;
                        if (s_op == OP_RD_DROP) begin
                            st_d.arr[s_idx].valid = 1'b0;
                            st_d.arr[s_idx].dirty = '0;
                        end
                    end
                end
                OP_WR_SINK: begin
                    if (s_dirty) begin
                        st_d.inh = 1'b1;
                        st_d.ack = 1'b1;
                        st_d.arr[s_idx].data[s_lw]  = s_merged;
                        st_d.arr[s_idx].dirty[s_lw] = 1'b1;
                    end else if (s_hit) begin
                        st_d.arr[s_idx].valid = 1'b0;
                        st_d.arr[s_idx].dirty = '0;
                    end
                end
                OP_WR_DROP: begin
                    if (s_hit) begin
                        st_d.arr[s_idx].valid = 1'b0;
                        st_d.arr[s_idx].dirty = '0;
                    end
                end
                default: ;
            endcase
        end else if (ins_valid) begin
            st_d.arr[i_idx].tag   = ins_addr[AW-5:IW];
            st_d.arr[i_idx].valid = 1'b1;
            st_d.arr[i_idx].dirty = '0;
            st_d.arr[i_idx].data  = ins_data;
        end else if (cpu_req) begin
            st_d.cdone = 1'b1;
            st_d.chit  = c_hit;
            if (c_hit) begin
                st_d.crd = c_old;
                if (cpu_write) begin
                    st_d.crd = c_merged;
                    st_d.arr[c_idx].data[c_lw] = c_merged;
                    if (cpu_copyback)
                        st_d.arr[c_idx].dirty[c_lw] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snp_inhibit = st_q.inh;
    assign snp_ack     = st_q.ack;
    assign snp_rdata   = st_q.srd;
    assign cpu_done    = st_q.cdone;
    assign cpu_hit     = st_q.chit;
    assign cpu_rdata   = st_q.crd;
    assign cpu_stall   = cpu_req && (snp_valid || ins_valid);

    assert_quiet_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_code == 2'b00 || snp_code == 2'b11)) |=> !snp_inhibit);

    assert_line_write_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_write && snp_size == SZ_LINE) |=> !snp_inhibit);

    assert_cpu_yields_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !$past(snp_valid));

    assert_inhibit_follows_R14: assert property (@(posedge clk) disable iff (!rst_n)
        snp_inhibit |-> $past(snp_valid));

    assert_clean_read_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_write && !s_dirty) |=> !snp_inhibit);
endmodule

// File: tb/sim_snoop_ctrl.sv
module sim_snoop_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        cache_en = 1'b1;
    logic        snp_valid = 0, snp_write = 0;
    logic [1:0]  snp_code = 0, snp_size = 0;
    logic [31:0] snp_addr = 0, snp_wdata = 0;
    logic        snp_inhibit, snp_ack;
    logic [31:0] snp_rdata;
    logic        ins_valid = 0;
    logic [27:0] ins_addr = 0;
    logic [127:0] ins_data = 0;
    logic        cpu_req = 0, cpu_write = 0, cpu_copyback = 0;
    logic [29:0] cpu_addr = 0;
    logic [3:0]  cpu_be = 0;
    logic [31:0] cpu_wdata = 0;
    logic        cpu_stall, cpu_done, cpu_hit;
    logic [31:0] cpu_rdata;

    snoop_ctrl u0 (.*);

    int checks = 0;
    int errors = 0;
    bit over = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic [31:0] ba(input [24:0] tag, input [2:0] idx, input [1:0] lw, input [1:0] b);
        return {tag, idx, lw, b};
    endfunction

    task automatic install(input [24:0] tag, input [2:0] idx, input [127:0] d);
        @(negedge clk);
        ins_valid = 1; ins_addr = {tag, idx}; ins_data = d;
        @(negedge clk);
        ins_valid = 0;
    endtask

    task automatic snoop(input w, input [1:0] code, input [1:0] size, input [31:0] a,
                         input [31:0] d, output logic inh, output logic ack, output logic [31:0] rd);
        @(negedge clk);
        snp_valid = 1; snp_write = w; snp_code = code; snp_size = size; snp_addr = a; snp_wdata = d;
        @(negedge clk);
        inh = snp_inhibit; ack = snp_ack; rd = snp_rdata;
        snp_valid = 0;
    endtask

    task automatic cpu(input w, input cb, input [31:0] a, input [3:0] be, input [31:0] d,
                       output logic hit, output logic [31:0] rd);
        @(negedge clk);
        cpu_req = 1; cpu_write = w; cpu_copyback = cb; cpu_addr = a[31:2]; cpu_be = be; cpu_wdata = d;
        @(negedge clk);
        hit = cpu_hit; rd = cpu_rdata;
        cpu_req = 0; cpu_write = 0;
    endtask

    localparam [127:0] LD = {32'h33333333, 32'h22222222, 32'h11111111, 32'h00000000};

    task automatic t_reset();
        chk("R14 reset inhibit", snp_inhibit, 0);
        chk("R14 reset ack", snp_ack, 0);
        chk("R14 reset done", cpu_done, 0);
    endtask

    task automatic t_copyback_and_supply();
        logic h, i, k; logic [31:0] r;
        install(25'h1, 3'd1, LD);
        cpu(1, 1, ba(25'h1, 1, 1, 0), 4'b1111, 32'hCAFE0001, h, r);
        chk("R9 cpu cb hit", h, 1);
        @(negedge clk);
        snp_valid = 1; snp_write = 0; snp_code = 2'b01; snp_size = 2'b10; snp_addr = ba(25'h1, 1, 1, 0);
        #1 chk("R14 not before edge", snp_inhibit, 0);
        @(negedge clk);
        chk("R2 inhibit", snp_inhibit, 1);
        chk("R2 ack", snp_ack, 1);
        chk("R9 R2 supplied data", snp_rdata, 32'hCAFE0001);
        snp_valid = 0;
        snoop(0, 2'b01, 2'b10, ba(25'h1, 1, 1, 0), 0, i, k, r);
        chk("R2 stays dirty", i, 1);
    endtask

    task automatic t_quiet_codes();
        logic h, i, k; logic [31:0] r;
        snoop(0, 2'b00, 2'b10, ba(25'h1, 1, 1, 0), 0, i, k, r);
        chk("R1 code00 read", {i, k}, 0);
        snoop(0, 2'b11, 2'b10, ba(25'h1, 1, 1, 0), 0, i, k, r);
        chk("R1 code11 read", {i, k}, 0);
        snoop(1, 2'b11, 2'b10, ba(25'h1, 1, 1, 0), 32'hDEADDEAD, i, k, r);
        chk("R1 code11 write", {i, k}, 0);
        snoop(1, 2'b00, 2'b11, ba(25'h1, 1, 1, 0), 32'hDEADDEAD, i, k, r);
        chk("R1 code00 line write", {i, k}, 0);
        cpu(0, 0, ba(25'h1, 1, 1, 0), 0, 0, h, r);
        chk("R1 data unchanged", r, 32'hCAFE0001);
        chk("R1 still valid", h, 1);
    endtask

    task automatic t_sink();
        logic h, i, k; logic [31:0] r;
        snoop(1, 2'b01, 2'b00, ba(25'h1, 1, 2, 2), 32'hAABBCCDD, i, k, r);
        chk("R7 byte inhibit", i, 1);
        chk("R7 byte ack", k, 1);
        cpu(0, 0, ba(25'h1, 1, 2, 0), 0, 0, h, r);
        chk("R7 R13 byte lane 2", r, 32'h22BB2222);
        snoop(1, 2'b01, 2'b01, ba(25'h1, 1, 3, 2), 32'hAABBCCDD, i, k, r);
        chk("R7 word inhibit", i, 1);
        cpu(0, 0, ba(25'h1, 1, 3, 0), 0, 0, h, r);
        chk("R7 R13 word upper", r, 32'hAABB3333);
        snoop(1, 2'b01, 2'b01, ba(25'h1, 1, 0, 0), 32'hAABBCCDD, i, k, r);
        cpu(0, 0, ba(25'h1, 1, 0, 0), 0, 0, h, r);
        chk("R7 R13 word lower", r, 32'h0000CCDD);
        snoop(1, 2'b01, 2'b10, ba(25'h1, 1, 0, 0), 32'h12345678, i, k, r);
        cpu(0, 0, ba(25'h1, 1, 0, 0), 0, 0, h, r);
        chk("R7 R13 long", r, 32'h12345678);
        snoop(0, 2'b01, 2'b10, ba(25'h1, 1, 0, 0), 0, i, k, r);
        chk("R7 sunk lw supplied", r, 32'h12345678);
    endtask

    task automatic t_read_drop();
        logic h, i, k; logic [31:0] r;
        snoop(0, 2'b10, 2'b10, ba(25'h1, 1, 3, 0), 0, i, k, r);
        chk("R3 inhibit", i, 1);
        chk("R3 data", r, 32'hAABB3333);
        cpu(0, 0, ba(25'h1, 1, 3, 0), 0, 0, h, r);
        chk("R3 line invalid", h, 0);
    endtask

    task automatic t_clean_read();
        logic h, i, k; logic [31:0] r;
        install(25'h2, 3'd2, LD);
        snoop(0, 2'b01, 2'b10, ba(25'h2, 2, 1, 0), 0, i, k, r);
        chk("R4 clean code01", {i, k}, 0);
        snoop(0, 2'b10, 2'b10, ba(25'h2, 2, 1, 0), 0, i, k, r);
        chk("R4 clean code10", {i, k}, 0);
        snoop(0, 2'b01, 2'b10, ba(25'h7, 2, 1, 0), 0, i, k, r);
        chk("R4 miss", {i, k}, 0);
        cpu(0, 0, ba(25'h2, 2, 1, 0), 0, 0, h, r);
        chk("R4 line kept", {31'd0, h}, 1);
        chk("R4 data kept", r, 32'h11111111);
    endtask

    task automatic t_sink_clean();
        logic h, i, k; logic [31:0] r;
        snoop(1, 2'b01, 2'b00, ba(25'h2, 2, 1, 1), 32'hFFFFFFFF, i, k, r);
        chk("R8 no inhibit", {i, k}, 0);
        cpu(0, 0, ba(25'h2, 2, 1, 0), 0, 0, h, r);
        chk("R8 invalidated", h, 0);
    endtask

    task automatic t_write_inval();
        logic h, i, k; logic [31:0] r;
        install(25'h3, 3'd3, LD);
        cpu(1, 1, ba(25'h3, 3, 0, 0), 4'b0001, 32'h000000EE, h, r);
        snoop(1, 2'b10, 2'b10, ba(25'h3, 3, 2, 0), 32'h5, i, k, r);
        chk("R5 no inhibit", i, 0);
        cpu(0, 0, ba(25'h3, 3, 0, 0), 0, 0, h, r);
        chk("R5 invalidated", h, 0);
    endtask

    task automatic t_line_write();
        logic h, i, k; logic [31:0] r;
        install(25'h4, 3'd4, LD);
        cpu(1, 1, ba(25'h4, 4, 2, 0), 4'b1111, 32'h77, h, r);
        snoop(1, 2'b01, 2'b11, ba(25'h4, 4, 0, 0), 32'h9, i, k, r);
        chk("R6 no inhibit on dirty", i, 0);
        cpu(0, 0, ba(25'h4, 4, 2, 0), 0, 0, h, r);
        chk("R6 invalidated", h, 0);
    endtask

    task automatic t_write_through();
        logic h, i, k; logic [31:0] r;
        install(25'h5, 3'd5, LD);
        cpu(1, 0, ba(25'h5, 5, 0, 0), 4'b0110, 32'h00ABCD00, h, r);
        chk("R10 hit", h, 1);
        cpu(0, 0, ba(25'h5, 5, 0, 0), 0, 0, h, r);
        chk("R10 data", r, 32'h00ABCD00);
        snoop(0, 2'b01, 2'b10, ba(25'h5, 5, 0, 0), 0, i, k, r);
        chk("R10 still clean", i, 0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        snp_valid = 1; snp_write = 0; snp_code = 2'b01; snp_size = 2'b10; snp_addr = ba(25'h6, 6, 0, 0);
        cpu_req = 1; cpu_write = 0; cpu_addr = ba(25'h5, 5, 0, 0) >> 2;
        #1 chk("R11 stall", cpu_stall, 1);
        @(negedge clk);
        chk("R11 no done", cpu_done, 0);
        snp_valid = 0;
        #1 chk("R11 stall released", cpu_stall, 0);
        @(negedge clk);
        chk("R11 done later", cpu_done, 1);
        chk("R11 result", cpu_rdata, 32'h00ABCD00);
        cpu_req = 0;
    endtask

    task automatic t_disabled();
        logic h, i, k; logic [31:0] r;
        install(25'h6, 3'd6, LD);
        cpu(1, 1, ba(25'h6, 6, 1, 0), 4'b1111, 32'hBEEF, h, r);
        cache_en = 0;
        cpu(0, 0, ba(25'h6, 6, 1, 0), 0, 0, h, r);
        chk("R12 disabled miss", h, 0);
        cpu(1, 1, ba(25'h6, 6, 2, 0), 4'b1111, 32'h99, h, r);
        snoop(0, 2'b01, 2'b10, ba(25'h6, 6, 1, 0), 0, i, k, r);
        chk("R12 snoop while disabled", i, 1);
        chk("R12 snoop data", r, 32'hBEEF);
        cache_en = 1;
        cpu(0, 0, ba(25'h6, 6, 2, 0), 0, 0, h, r);
        chk("R12 no write while disabled", r, 32'h22222222);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_copyback_and_supply();
        t_quiet_codes();
        t_sink();
        t_read_drop();
        t_clean_read();
        t_sink_clean();
        t_write_inval();
        t_line_write();
        t_write_through();
        t_priority();
        t_disabled();
        if (!over) begin
            over = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!over) begin
            over = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule